// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a binary counter, four bits wide by default, with no direction pin. It has one strobe that counts up and another that counts down, and the strobe that pulses sets the direction. Both strobes idle high. A count step happens when a strobe rises. The block runs on one fast system clock. Each strobe is resynchronized in a two-flop stage, and its rising edge is detected on the synchronized level.

A synchronous preset copies a parallel value into the counter, and a clear forces the counter to zero. Both act whatever the strobes are doing. Loading a preset shortens the count cycle, so the block can act as a programmable divider.

There are two active-low terminal outputs, one for the top of the range and one for the bottom. Each one goes low while the counter sits at its limit and the matching strobe is low. It rises on the same clock edge as the wrap-around. Because of this, the outputs can drive the up and down strobes of a following stage directly, and several stages chain into a wider counter.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `upStrobe` adds one to `count`, and `count` wraps from 15 to 0.
- R2: A rising edge on `downStrobe` subtracts one from `count`, and `count` wraps from 0 to 15.
- R3: While `loadN` is 0 (and `clear` is 0), `count` takes `presetVal` at the next clock edge. Strobe edges that arrive during a load are ignored.
- R4: While `clear` is 1, `count` becomes 0 at the next clock edge. Clear wins over load and over counting.
- R5: `carryN` is 0 only while `count` is 15 and the synchronized up strobe is low. It returns to 1 on the same clock edge on which `count` wraps to 0.
- R6: `borrowN` is 0 only while `count` is 0 and the synchronized down strobe is low. It returns to 1 on the same clock edge on which `count` wraps to 15.
- R7: If both strobes rise in the same synchronized cycle, `count` holds.
- R8: A strobe rising between clock edges changes `count` at the third rising clock edge after it, and not earlier.
- R9: Two stages, with `carryN` wired to the next `upStrobe` and `borrowN` wired to the next `downStrobe`, count as one 8-bit counter in both directions.
- R10: After reset, `count` is 0 and both `carryN` and `borrowN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upStrobe | input | 1 | Count-up strobe, idles high, counts on rise |
| downStrobe | input | 1 | Count-down strobe, idles high, counts on rise |
| loadN | input | 1 | Active-low synchronous preset |
| clear | input | 1 | Active-high synchronous clear |
| presetVal | input | WIDTH | Value loaded by `loadN` |
| count | output | WIDTH | Current count |
| carryN | output | 1 | Low at the top of the range while up strobe is low |
| borrowN | output | 1 | Low at zero while down strobe is low |

## Verification
Two functions can land on the same clock edge: a strobe edge and a load or clear. The bench provokes this by driving a complete up pulse while `loadN` is held low, and by asserting clear and load together. It judges the result by checking that the count equals the preset (or zero), with no late increment once the load is released. A second collision is both strobes rising on the same edge, which must leave the count unchanged. The wrap edge is also tested: the count and the terminal output must change at the same sampled cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic clr;      // clear this cycle
    logic ld;       // load preset this cycle
    logic inc;      // count up this cycle
    logic dec;      // count down this cycle
    logic upHigh;   // delayed synchronized up strobe level
    logic downHigh; // delayed synchronized down strobe level
  } dscCtrl_t;
endpackage

// File: rtl/dsc_edge_sync.sv
module dsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise,
  output logic levelDly
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;   // idle-high strobes
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  assign rise     = chain[STAGES-1] & ~chain[STAGES];
  assign levelDly = chain[STAGES];
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     upStrobe,
  input  logic     downStrobe,
  input  logic     loadN,
  input  logic     clear,
  output dscCtrl_t ctrlBus,
  output logic [1:0] riseVec
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] strobeIn;
  logic [NUM_STROBES-1:0] levelVec;

  assign strobeIn = {downStrobe, upStrobe};

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_sync
    dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (strobeIn[i]),
      .rise    (riseVec[i]),
      .levelDly(levelVec[i])
    );
  end

  logic busy;
  assign busy = clear | ~loadN;

  always_comb begin
    ctrlBus          = '0;
    ctrlBus.clr      = clear;
    ctrlBus.ld       = ~loadN & ~clear;
    ctrlBus.inc      = ~busy & riseVec[0] & ~riseVec[1];
    ctrlBus.dec      = ~busy & riseVec[1] & ~riseVec[0];
    ctrlBus.upHigh   = levelVec[0];
    ctrlBus.downHigh = levelVec[1];
  end

  // R3: a load suppresses both count steps
  p_load_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |-> !(ctrlBus.inc || ctrlBus.dec));
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dscCtrl_t         ctrlBus,
  input  logic [WIDTH-1:0] presetVal,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = count;
    if (ctrlBus.clr)      countNext = '0;
    else if (ctrlBus.ld)  countNext = presetVal;
    else if (ctrlBus.inc) countNext = count + ONE_VAL;
    else if (ctrlBus.dec) countNext = count - ONE_VAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  assign carryN  = ~((count == TOP_VAL) & ~ctrlBus.upHigh);
  assign borrowN = ~((count == '0)      & ~ctrlBus.downHigh);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.clr |=> count == '0);
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.ld |=> count == $past(presetVal));
  p_inc_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.inc |=> count == WIDTH'($past(count) + ONE_VAL));
  p_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.dec |=> count == WIDTH'($past(count) - ONE_VAL));
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upStrobe,
  input  logic             downStrobe,
  input  logic             loadN,
  input  logic             clear,
  input  logic [WIDTH-1:0] presetVal,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  dscCtrl_t   ctrlBus;
  logic [1:0] riseVec;

  dsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .upStrobe(upStrobe), .downStrobe(downStrobe),
    .loadN(loadN), .clear(clear), .ctrlBus(ctrlBus), .riseVec(riseVec)
  );

  dsc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .presetVal(presetVal),
    .count(count), .carryN(carryN), .borrowN(borrowN)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec == 2'b11 && loadN && !clear) |=> $stable(count));
  p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(carryN) && $past(ctrlBus.inc)) |-> count == '0);
  p_borrow_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(borrowN) && $past(ctrlBus.dec)) |-> count == '1);
endmodule

// File: tb/tb_dual_strobe_counter.sv
module tb_dual_strobe_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, upStrobe, downStrobe, loadN, clear;
  logic [3:0] presetVal, count;
  logic carryN, borrowN;

  logic cUp, cDown;
  logic [3:0] loCount, hiCount;
  logic loCarryN, loBorrowN, hiCarryN, hiBorrowN;

  int checks = 0;
  int errors = 0;

  dual_strobe_counter dut (
    .clk(clk), .rstN(rstN), .upStrobe(upStrobe), .downStrobe(downStrobe),
    .loadN(loadN), .clear(clear), .presetVal(presetVal),
    .count(count), .carryN(carryN), .borrowN(borrowN)
  );

  dual_strobe_counter chainLo (
    .clk(clk), .rstN(rstN), .upStrobe(cUp), .downStrobe(cDown),
    .loadN(1'b1), .clear(1'b0), .presetVal(4'd0),
    .count(loCount), .carryN(loCarryN), .borrowN(loBorrowN)
  );

  dual_strobe_counter chainHi (
    .clk(clk), .rstN(rstN), .upStrobe(loCarryN), .downStrobe(loBorrowN),
    .loadN(1'b1), .clear(1'b0), .presetVal(4'd0),
    .count(hiCount), .carryN(hiCarryN), .borrowN(hiBorrowN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseUp();
    upStrobe = 1'b0; step(4); upStrobe = 1'b1; step(4);
  endtask

  task automatic pulseDown();
    downStrobe = 1'b0; step(4); downStrobe = 1'b1; step(4);
  endtask

  task automatic loadValue(input int v);
    presetVal = 4'(v); loadN = 1'b0; step(1); loadN = 1'b1; step(1);
  endtask

  task automatic testReset();
    check("R10 count", count, 0);
    check("R10 carryN", carryN, 1);
    check("R10 borrowN", borrowN, 1);
  endtask

  task automatic testSyncLatency();
    upStrobe = 1'b0; step(4);
    upStrobe = 1'b1;
    step(2); check("R8 before third edge", count, 0);
    step(1); check("R8 at third edge", count, 1);
    step(2);
  endtask

  task automatic testUp();
    pulseUp(); pulseUp();
    check("R1 up count", count, 3);
  endtask

  task automatic testDownWrap();
    for (int i = 0; i < 4; i++) pulseDown();
    check("R2 down wrap", count, 15);
  endtask

  task automatic testCarry();
    loadValue(15);
    check("R3 load", count, 15);
    check("R5 carry idle", carryN, 1);
    upStrobe = 1'b0; step(4);
    check("R5 carry low", carryN, 0);
    upStrobe = 1'b1; step(2);
    check("R5 carry still low", carryN, 0);
    step(1);
    check("R5 carry rose", carryN, 1);
    check("R1 wrap to zero", count, 0);
    step(2);
  endtask

  task automatic testBorrow();
    downStrobe = 1'b0; step(4);
    check("R6 borrow low", borrowN, 0);
    downStrobe = 1'b1; step(3);
    check("R6 borrow rose", borrowN, 1);
    check("R2 wrap to fifteen", count, 15);
    step(2);
  endtask

  task automatic testLoadIgnoresStrobe();
    loadValue(5);
    presetVal = 4'd9; loadN = 1'b0;
    upStrobe = 1'b0; step(3); upStrobe = 1'b1; step(5);
    loadN = 1'b1; step(4);
    check("R3 strobe ignored during load", count, 9);
  endtask

  task automatic testClearPriority();
    loadValue(10);
    presetVal = 4'd7; loadN = 1'b0; clear = 1'b1; step(2);
    check("R4 clear over load", count, 0);
    clear = 1'b0; loadN = 1'b1; step(2);
    check("R4 stays zero", count, 0);
  endtask

  task automatic testBothStrobes();
    loadValue(6);
    upStrobe = 1'b0; downStrobe = 1'b0; step(4);
    upStrobe = 1'b1; downStrobe = 1'b1; step(6);
    check("R7 hold on double rise", count, 6);
  endtask

  task automatic chainUp();
    cUp = 1'b0; step(4); cUp = 1'b1; step(8);
  endtask

  task automatic chainDown();
    cDown = 1'b0; step(4); cDown = 1'b1; step(8);
  endtask

  task automatic testChain();
    for (int i = 0; i < 20; i++) chainUp();
    check("R9 chain up", {hiCount, loCount}, 20);
    for (int i = 0; i < 5; i++) chainDown();
    check("R9 chain down", {hiCount, loCount}, 15);
    for (int i = 0; i < 16; i++) chainDown();
    check("R9 chain underflow", {hiCount, loCount}, 255);
    chainUp();
    check("R9 chain overflow", {hiCount, loCount}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; upStrobe = 1'b1; downStrobe = 1'b1; loadN = 1'b1;
    clear = 1'b0; presetVal = 4'd0; cUp = 1'b1; cDown = 1'b1;
    step(3); rstN = 1'b1; step(2);
    testReset();
    testSyncLatency();
    testUp();
    testDownWrap();
    testCarry();
    testBorrow();
    testLoadIgnoresStrobe();
    testClearPriority();
    testBothStrobes();
    testChain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule